// File: doc/BRIEF.md
# Oscillator Run Controller

This block decides whether one on-chip oscillator may stop. It produces two signals for the oscillator: a run enable, registered on the oscillator's own clock, and a wake request. The wake request is a gated copy of a peripheral's asynchronous request, so it can restart an oscillator that has no clock.

Once the oscillator runs again and the CPU state machines leave idle, the registered enable takes over and keeps the oscillator running. The wake request is then retired by a short release chain clocked by the oscillator. That chain is armed at once whenever the global interrupt enable is high. When the flag drops, the chain lets the request go after a fixed number of oscillator edges.

One instance serves the fast oscillator, with its off bit driven by the matching status bit. Another serves the slow oscillator. A build parameter can remove the logic, and both outputs are then tied high. In test mode the enable is forced on. The release chain is then armed only by the chip reset.

Top module: `osc_wake_ctrl`

## Requirements
- R1: While `rst_n` is low and at least one oscillator edge has occurred, `osc_enable` is 1 and the release chain is armed, so `osc_wkup` equals `wake_req`.
- R2: At each rising `osc_clk` edge outside reset, `osc_enable` becomes 0 exactly when `osc_off` and `cpu_idle` are both 1 at that edge, and otherwise becomes 1.
- R3: While `cpu_idle` is 0, `osc_enable` stays 1 even with `osc_off` at 1, so an instruction that sets the off bit completes before the oscillator stops.
- R4: From the stopped state, `osc_enable` returns to 1 on the first edge at which `osc_off` is 0 or `cpu_idle` is 0.
- R5: With `gie` at 1 outside test mode, `osc_wkup` follows `wake_req` with no clock edge in between.
- R6: After `gie` falls, `osc_wkup` stays equal to `wake_req` through the first oscillator edge and goes to 0 at the second edge (RELEASE_STAGES = 2).
- R7: If `wake_req` is still 1 when `gie` returns to 1, `osc_wkup` returns to 1 at once, without a clock edge.
- R8: With `scan_mode` at 1, `osc_enable` is 1 whatever `osc_off` and `cpu_idle` are. `gie` then does not arm the release chain, but a low `rst_n` does.
- R9: With CTRL_EN = 0, `osc_enable` and `osc_wkup` are both constantly 1.
- R10: `osc_wkup` is 0 whenever `wake_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Clock produced by the controlled oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_mode | input | 1 | Test mode: forces the enable on and restricts the arming of the release chain to reset |
| osc_off | input | 1 | Oscillator-off status bit from the CPU |
| cpu_idle | input | 1 | CPU state machines are in their idle state |
| gie | input | 1 | Global interrupt enable flag |
| wake_req | input | 1 | Asynchronous wake request from peripherals |
| osc_enable | output | 1 | Registered run enable for the oscillator |
| osc_wkup | output | 1 | Asynchronous wake request for the oscillator |

## Verification
The stopping of the enable and the end of the wake release are driven by independent inputs, yet both can land on the same oscillator edge. The bench first lowers `gie` with `wake_req` held high. One edge later it raises `osc_off` and `cpu_idle` together, so the second release edge is also the edge that clears the enable. It then checks that both outputs have fallen after that single edge. The enable logic is swept over every pair of consecutive `osc_off`/`cpu_idle` combinations, and each result is compared with the arithmetic rule. The asynchronous paths are checked between clock edges.

// File: rtl/osc_wake_pkg.sv
package osc_wake_pkg;

  // Value the run enable takes at the next oscillator edge.
  function automatic logic run_next(input logic off_bit, input logic idle);
    return !(off_bit && idle);
  endfunction

  // Level that arms (presets) the release chain.
  // In test mode only the chip reset may arm it.
  function automatic logic arm_level(input logic rst_n, input logic scan,
                                     input logic gie);
    return scan ? !rst_n : (!rst_n || gie);
  endfunction

endpackage

// File: rtl/osc_run_reg.sv
module osc_run_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic off_bit,
  input  logic idle,
  output logic run_q
);
  import osc_wake_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b1;
    else        run_q <= run_next(off_bit, idle);
  end

  // R2: off bit and idle together stop the oscillator at the next edge
  p_stop_on_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (off_bit && idle) |=> !run_q);
  // R4: either condition gone restarts the enable at the next edge
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(off_bit && idle) |=> run_q);
  // R3: a busy CPU keeps the oscillator running
  p_busy_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> run_q);

endmodule

// File: rtl/osc_release_chain.sv
module osc_release_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arm,
  output logic gate
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or posedge arm) begin
    if (arm) shreg <= '1;
    else     shreg <= shreg << 1;
  end

  assign gate = shreg[STAGES-1];

endmodule

// File: rtl/osc_and_cell.sv
module osc_and_cell (
  input  logic a,
  input  logic b,
  output logic y
);
  assign y = a & b;
endmodule

// File: rtl/osc_wake_ctrl.sv
module osc_wake_ctrl #(
  parameter bit CTRL_EN        = 1'b1,
  parameter int RELEASE_STAGES = 2
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic scan_mode,
  input  logic osc_off,
  input  logic cpu_idle,
  input  logic gie,
  input  logic wake_req,
  output logic osc_enable,
  output logic osc_wkup
);
  import osc_wake_pkg::*;

  localparam int CW = $clog2(RELEASE_STAGES + 1);

  generate
    if (CTRL_EN) begin : g_ctrl
      logic run_q;
      logic arm;
      logic gate;

      osc_run_reg i_run (
        .clk(osc_clk), .rst_n(rst_n), .off_bit(osc_off),
        .idle(cpu_idle), .run_q(run_q)
      );

      assign arm = arm_level(rst_n, scan_mode, gie);

      osc_release_chain #(.STAGES(RELEASE_STAGES)) i_chain (
        .clk(osc_clk), .arm(arm), .gate(gate)
      );

      osc_and_cell i_and (.a(wake_req), .b(gate), .y(osc_wkup));

      assign osc_enable = run_q | scan_mode;

      // Checker state: consecutive edges with the flag low in functional mode.
      logic [CW-1:0] low_cnt;
      always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n)                     low_cnt <= '0;
        else if (gie || scan_mode)      low_cnt <= '0;
        else if (low_cnt != CW'(RELEASE_STAGES)) low_cnt <= low_cnt + CW'(1);
      end

      // R6: after RELEASE_STAGES low samples the chain has let go
      p_release_done_r6: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (low_cnt == CW'(RELEASE_STAGES) && !gie && !scan_mode) |-> !gate);
      // R5: flag high keeps the chain armed
      p_flag_arms_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (gie && !scan_mode) |-> gate);
      // R8: test mode always runs the oscillator
      p_scan_runs_r8: assert property (@(posedge osc_clk) disable iff (!rst_n)
        scan_mode |-> osc_enable);
      // R10: no wake output without a request
      p_wkup_needs_req_r10: assert property (@(posedge osc_clk) disable iff (!rst_n)
        osc_wkup |-> wake_req);
    end else begin : g_tied
      logic tie_unused;
      assign tie_unused = ^{osc_clk, rst_n, scan_mode, osc_off, cpu_idle, gie, wake_req};
      assign osc_enable = 1'b1;
      assign osc_wkup   = 1'b1;
    end
  endgenerate

endmodule

// File: tb/test_osc_wake_ctrl.sv
module test_osc_wake_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_mode = 1'b0;
  logic osc_off = 1'b0;
  logic cpu_idle = 1'b0;
  logic gie = 1'b0;
  logic wake_req = 1'b0;
  logic osc_enable, osc_wkup;
  logic tied_en, tied_wk;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  osc_wake_ctrl i_osc_wake_ctrl (
    .osc_clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .osc_off(osc_off),
    .cpu_idle(cpu_idle), .gie(gie), .wake_req(wake_req),
    .osc_enable(osc_enable), .osc_wkup(osc_wkup)
  );

  osc_wake_ctrl #(.CTRL_EN(1'b0)) i_osc_wake_ctrl_tied (
    .osc_clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .osc_off(osc_off),
    .cpu_idle(cpu_idle), .gie(gie), .wake_req(wake_req),
    .osc_enable(tied_en), .osc_wkup(tied_wk)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Advance one edge and sample 1 ns after it.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    // R1: reset state
    chk("R1 enable in reset", osc_enable, 1'b1);
    wake_req = 1'b1; #1;
    chk("R1 chain armed in reset", osc_wkup, 1'b1);
    wake_req = 1'b0; #1;
    chk("R10 no request", osc_wkup, 1'b0);
    chk("R9 tied enable", tied_en, 1'b1);
    chk("R9 tied wkup", tied_wk, 1'b1);
    cyc();
    rst_n = 1'b1;
    cyc();

    // R2 / R4: every pair of consecutive off/idle combinations
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 4; n++) begin
        osc_off = p[1]; cpu_idle = p[0];
        cyc();
        osc_off = n[1]; cpu_idle = n[0];
        cyc();
        chk("R2 R4 enable rule", osc_enable, !(n[1] && n[0]));
      end
    end

    // R3: busy CPU holds the enable for several edges
    osc_off = 1'b1; cpu_idle = 1'b0;
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk("R3 busy hold", osc_enable, 1'b1);
    end
    cpu_idle = 1'b1;
    cyc();
    chk("R3 stop after idle", osc_enable, 1'b0);
    osc_off = 1'b0;
    cyc();
    chk("R4 restart", osc_enable, 1'b1);

    // R5: asynchronous follow while the flag is high
    gie = 1'b1;
    cyc();
    wake_req = 1'b1; #1;
    chk("R5 async set", osc_wkup, 1'b1);
    wake_req = 1'b0; #1;
    chk("R10 async clear", osc_wkup, 1'b0);

    // R6: two-edge release
    cyc();
    wake_req = 1'b1;
    gie = 1'b0; #1;
    chk("R6 held before edge", osc_wkup, 1'b1);
    cyc();
    chk("R6 held after first edge", osc_wkup, 1'b1);
    cyc();
    chk("R6 released at second edge", osc_wkup, 1'b0);
    cyc();
    chk("R6 stays released", osc_wkup, 1'b0);

    // R7: flag restored with request still pending
    gie = 1'b1; #1;
    chk("R7 reassert", osc_wkup, 1'b1);

    // Same edge: release completes and enable stops
    cyc();
    gie = 1'b0;
    cyc();
    osc_off = 1'b1; cpu_idle = 1'b1;
    cyc();
    chk("R6 release on shared edge", osc_wkup, 1'b0);
    chk("R2 stop on shared edge", osc_enable, 1'b0);
    osc_off = 1'b0;
    cyc();

    // R8: test mode
    scan_mode = 1'b1; osc_off = 1'b1; cpu_idle = 1'b1;
    cyc(); cyc();
    chk("R8 enable forced", osc_enable, 1'b1);
    gie = 1'b0; wake_req = 1'b1;
    cyc(); cyc();
    gie = 1'b1; #1;
    chk("R8 flag ignored", osc_wkup, 1'b0);
    rst_n = 1'b0; #1;
    chk("R8 reset arms", osc_wkup, 1'b1);
    chk("R8 enable in reset", osc_enable, 1'b1);
    cyc();
    rst_n = 1'b1; scan_mode = 1'b0; osc_off = 1'b0;
    cyc();
    chk("R9 tied enable late", tied_en, 1'b1);
    chk("R9 tied wkup late", tied_wk, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule